// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Unit

This block refills one cache line after a miss. It takes a miss address and an order selection, issues a single burst request to a memory port that returns one word per valid beat, and writes every returned word into a line buffer at that word's own index. The word that caused the miss is handed to the processor in the cycle after its beat arrives. The processor does not wait for the whole line.

Two fill orders are available. In wrapped order, memory is asked for the missed word first, and the burst then wraps through the rest of the line. In ascending order, memory is asked for word 0 first and the words follow in ascending order. The missed word is still forwarded as soon as its beat is seen, even when lower words arrived before it. A single-cycle completion strobe marks the end of the line. From that cycle on, the unit can take the next miss.

Top module: `cwf_line_refill`

## Requirements
- R1: While reset is asserted (rst_n low), and in the first cycle after it, busy, mem_req_valid, cpu_valid and line_done are all low.
- R2: A miss is accepted when miss_valid is high and busy is low. From the next cycle busy stays high until the line completes. miss_valid raised while busy is ignored.
- R3: After acceptance, mem_req_valid is raised and held, with mem_req_addr and mem_req_wrap unchanged, until a cycle in which mem_req_ready is high. It is low in the next cycle.
- R4: With miss_mode = 1 (wrapped order), mem_req_addr is the miss address with its low 3 bits cleared and mem_req_wrap = 1. With miss_mode = 0 (ascending order), mem_req_addr is the 64-byte line base (low 6 bits cleared) and mem_req_wrap = 0.
- R5: Let w = miss_addr[5:3]. The k-th valid beat after the request handshake (k from 0) is stored as word (w+k) mod 8 in wrapped order, and as word k in ascending order.
- R6: cpu_valid is high for exactly the one cycle that follows the beat holding word w. cpu_data then equals that beat's data. cpu_valid is low in every other cycle of the refill.
- R7: cpu_valid is raised exactly once for each accepted miss.
- R8: Cycles in which beat_valid is low do not advance the fill and do not write the buffer. Beats presented before the request handshake completes are ignored.
- R9: line_done is high for one cycle, the cycle after the eighth valid beat, and busy is low in that cycle. line_data then holds word i at bits [64*i+63 : 64*i], the same layout in both orders.
- R10: A miss presented in the cycle in which line_done is high is accepted. busy and mem_req_valid are high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_addr | input | 32 | Byte address that missed |
| miss_mode | input | 1 | 1 = wrapped order starting at the missed word, 0 = ascending order |
| busy | output | 1 | Refill in progress; new misses refused |
| mem_req_valid | output | 1 | Burst request to memory |
| mem_req_ready | input | 1 | Memory accepts the burst request |
| mem_req_addr | output | 32 | Address of the first word of the burst |
| mem_req_wrap | output | 1 | Burst wraps inside the line |
| beat_valid | input | 1 | A memory data beat is present |
| beat_data | input | 64 | Memory data word |
| cpu_valid | output | 1 | Missed word returned to the processor |
| cpu_data | output | 64 | The missed word |
| line_done | output | 1 | Line buffer complete |
| line_data | output | 512 | Filled line, word i at bits [64*i+63 : 64*i] |

## Verification
The bench varies the missed word across the line, including word 0 and word 7 in both orders. A design that mis-wraps the index would file beats under the wrong word, and one that forwards on beat position rather than word index would return the wrong data in ascending order. Gap patterns between beats, including a gap before every beat, catch a counter that advances on idle cycles and so completes the line early. A miss raised mid-refill and a beat raised before the request handshake expose a design that restarts or stores stray data. A miss raised in the completion cycle catches a unit that holds busy one cycle too long.

// File: rtl/refill_pkg.sv
package refill_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ASK  = 2'd1,
      ST_FILL = 2'd2
   } refill_state_e;

   typedef enum logic {
      ORDER_ASCEND = 1'b0,
      ORDER_CRIT   = 1'b1
   } fill_order_e;

endpackage

// File: rtl/refill_order.sv
module refill_order #(
   parameter int WORDS = 8,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic [IDX_W-1:0] start_idx,
   input  logic [IDX_W-1:0] beat_cnt,
   input  logic [IDX_W-1:0] crit_idx,
   output logic [IDX_W-1:0] word_idx,
   output logic             is_crit
);

   // power-of-two line: the sum wraps by truncation
   always_comb begin
      word_idx = start_idx + beat_cnt;
      is_crit  = (word_idx == crit_idx);
   end

endmodule

// File: rtl/refill_linebuf.sv
module refill_linebuf #(
   parameter int WORDS          = 8,
   parameter int WORD_W         = 64,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [WORD_W-1:0]       wr_data,
   output logic [WORDS*WORD_W-1:0] line_flat
);

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [WORD_W-1:0] slot_q;
      logic              hit;
      assign hit = wr_en && (wr_idx == IDX_W'(i));
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)   slot_q <= '0;
            else if (hit) slot_q <= wr_data;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) slot_q <= wr_data;
         end
      end
      assign line_flat[i*WORD_W +: WORD_W] = slot_q;
   end

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
   import refill_pkg::*;
#(
   parameter int WORDS = 8,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_valid,
   input  logic             req_ready,
   input  logic             beat_valid,
   output logic             accept,
   output logic             busy,
   output logic             req_valid,
   output logic             beat_fire,
   output logic [IDX_W-1:0] beat_cnt,
   output logic             done
);

   refill_state_e state_q, state_d;
   logic [IDX_W-1:0] cnt_q, cnt_d;
   logic             done_q, last_beat;

   assign accept    = (state_q == ST_IDLE) && miss_valid;
   assign busy      = (state_q != ST_IDLE);
   assign req_valid = (state_q == ST_ASK);
   assign beat_fire = (state_q == ST_FILL) && beat_valid;
   assign last_beat = beat_fire && (cnt_q == IDX_W'(WORDS - 1));
   assign beat_cnt  = cnt_q;
   assign done      = done_q;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: if (miss_valid) state_d = ST_ASK;
         ST_ASK: begin
            if (req_ready) begin
               state_d = ST_FILL;
               cnt_d   = '0;
            end
         end
         ST_FILL: begin
            if (beat_fire) cnt_d = cnt_q + 1'b1;
            if (last_beat) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         done_q  <= last_beat;
      end
   end

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid);
   p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_valid);
   p_busy_from_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(miss_valid));
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: rtl/cwf_line_refill.sv
module cwf_line_refill
   import refill_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int WORD_W         = 64,
   parameter int LINE_BYTES     = 64,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int WORD_BYTES = WORD_W / 8,
   localparam int WORDS      = LINE_BYTES / WORD_BYTES,
   localparam int IDX_W      = $clog2(WORDS),
   localparam int OFF_W      = $clog2(WORD_BYTES),
   localparam int LINE_W     = WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic              miss_mode,
   output logic              busy,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic              mem_req_wrap,
   input  logic              beat_valid,
   input  logic [WORD_W-1:0] beat_data,
   output logic              cpu_valid,
   output logic [WORD_W-1:0] cpu_data,
   output logic              line_done,
   output logic [LINE_W-1:0] line_data
);

   localparam logic [ADDR_W-1:0] WORD_MASK = ADDR_W'(WORD_BYTES - 1);
   localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

   if (WORD_W % 8 != 0 || WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0)
   begin : g_bad_word
      $error("word width must be a power-of-two number of bytes");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0 || LINE_BYTES % WORD_BYTES != 0)
   begin : g_bad_line
      $error("line must hold a power-of-two count of at least two words");
   end
   if (ADDR_W <= IDX_W + OFF_W) begin : g_bad_addr
      $error("address too narrow for the line size");
   end

   logic              accept, beat_fire, is_crit;
   logic [IDX_W-1:0]  beat_cnt, word_idx, start_idx, crit_q;
   logic [ADDR_W-1:0] addr_q;
   fill_order_e       order_q;
   logic              fwd_q;
   logic [WORD_W-1:0] fwd_data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         order_q <= ORDER_ASCEND;
      end else if (accept) begin
         addr_q  <= miss_addr & ~WORD_MASK;
         order_q <= fill_order_e'(miss_mode);
      end
   end

   assign crit_q       = addr_q[OFF_W +: IDX_W];
   assign start_idx    = (order_q == ORDER_CRIT) ? crit_q : '0;
   assign mem_req_addr = (order_q == ORDER_CRIT) ? addr_q : (addr_q & ~LINE_MASK);
   assign mem_req_wrap = (order_q == ORDER_CRIT);

   refill_ctrl #(.WORDS(WORDS)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .req_ready  (mem_req_ready),
      .beat_valid (beat_valid),
      .accept     (accept),
      .busy       (busy),
      .req_valid  (mem_req_valid),
      .beat_fire  (beat_fire),
      .beat_cnt   (beat_cnt),
      .done       (line_done)
   );

   refill_order #(.WORDS(WORDS)) u_order (
      .start_idx (start_idx),
      .beat_cnt  (beat_cnt),
      .crit_idx  (crit_q),
      .word_idx  (word_idx),
      .is_crit   (is_crit)
   );

   refill_linebuf #(
      .WORDS          (WORDS),
      .WORD_W         (WORD_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (beat_fire),
      .wr_idx    (word_idx),
      .wr_data   (beat_data),
      .line_flat (line_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_q      <= 1'b0;
         fwd_data_q <= '0;
      end else begin
         fwd_q <= beat_fire && is_crit;
         if (beat_fire && is_crit) fwd_data_q <= beat_data;
      end
   end

   assign cpu_valid = fwd_q;
   assign cpu_data  = fwd_data_q;

   // checker state: whether the current line has already forwarded
   logic fwd_seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n)         fwd_seen_q <= 1'b0;
      else if (line_done) fwd_seen_q <= 1'b0;
      else if (cpu_valid) fwd_seen_q <= 1'b1;
   end

   p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr) && $stable(mem_req_wrap));
   p_no_second_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid |-> !fwd_seen_q);
   p_fwd_before_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> (fwd_seen_q || cpu_valid));
   p_fwd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid |=> !cpu_valid);
   p_fwd_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid |-> ($past(busy) && !mem_req_valid));
   p_first_beat_crit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      beat_fire && beat_cnt == '0 && order_q == ORDER_CRIT |=> cpu_valid);

endmodule

// File: tb/sim_cwf_line_refill.sv
module sim_cwf_line_refill;

   localparam int NW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0;
   logic [31:0]   miss_addr = '0;
   logic          miss_mode = 1'b0;
   logic          busy, mem_req_valid, mem_req_wrap;
   logic          mem_req_ready = 1'b0;
   logic [31:0]   mem_req_addr;
   logic          beat_valid = 1'b0;
   logic [63:0]   beat_data = '0;
   logic          cpu_valid, line_done;
   logic [63:0]   cpu_data;
   logic [511:0]  line_data;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   cwf_line_refill u0 (
      .clk (clk), .rst_n (rst_n),
      .miss_valid (miss_valid), .miss_addr (miss_addr), .miss_mode (miss_mode),
      .busy (busy),
      .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
      .mem_req_addr (mem_req_addr), .mem_req_wrap (mem_req_wrap),
      .beat_valid (beat_valid), .beat_data (beat_data),
      .cpu_valid (cpu_valid), .cpu_data (cpu_data),
      .line_done (line_done), .line_data (line_data)
   );

   // entry: [19] mode, [18:16] missed word, [15:8] gap before beat k, [7:0] seed
   localparam logic [19:0] VEC [8] = '{
      {1'b1, 3'd3, 8'h00, 8'h11},
      {1'b0, 3'd5, 8'h00, 8'h22},
      {1'b1, 3'd0, 8'h0F, 8'h33},
      {1'b0, 3'd0, 8'h80, 8'h44},
      {1'b1, 3'd7, 8'hA5, 8'h55},
      {1'b0, 3'd7, 8'h5A, 8'h66},
      {1'b1, 3'd4, 8'hFF, 8'h77},
      {1'b0, 3'd2, 8'h10, 8'h88}
   };

   function automatic logic [63:0] word_val(input logic [7:0] seed, input int i);
      return {seed, 8'(i), 16'hBEEF, seed ^ 8'(i), 24'h123456};
   endfunction

   function automatic logic [31:0] line_base(input logic [7:0] seed);
      return {18'h0_0A5, seed, 6'b0};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_miss(input bit mode, input int w, input logic [7:0] gaps,
                           input logic [7:0] seed, input bit chain);
      logic [31:0] exp_req;
      int          fwd_cnt = 0;
      @(negedge clk);
      miss_valid = 1'b1;
      miss_mode  = mode;
      miss_addr  = line_base(seed) + 32'(w * 8) + 32'd5;
      @(negedge clk);
      miss_valid = 1'b0;
      check(busy === 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
      check(mem_req_valid === 1'b1, "R3 request raised", 64'(mem_req_valid), 64'd1);
      exp_req = mode ? (line_base(seed) + 32'(w * 8)) : line_base(seed);
      check(mem_req_addr === exp_req, "R4 request address", 64'(mem_req_addr), 64'(exp_req));
      check(mem_req_wrap === mode, "R4 wrap flag", 64'(mem_req_wrap), 64'(mode));
      // R8: beat before the handshake must be ignored
      beat_valid = 1'b1;
      beat_data  = 64'hBAD0_BAD0_BAD0_BAD0;
      @(negedge clk);
      beat_valid = 1'b0;
      check(mem_req_valid === 1'b1 && mem_req_addr === exp_req, "R3 request held",
            64'(mem_req_addr), 64'(exp_req));
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      check(mem_req_valid === 1'b0, "R3 request dropped", 64'(mem_req_valid), 64'd0);
      for (int k = 0; k < NW; k++) begin
         int e = mode ? ((w + k) % NW) : k;
         if (gaps[k]) begin
            beat_valid = 1'b0;
            beat_data  = 64'hDEAD_0000_0000_0000 | 64'(k);
            @(negedge clk);
            check(cpu_valid === 1'b0 && line_done === 1'b0, "R8 idle beat",
                  64'({cpu_valid, line_done}), 64'd0);
         end
         beat_valid = 1'b1;
         beat_data  = word_val(seed, e);
         if (k == 3) begin
            miss_valid = 1'b1;
            miss_mode  = ~mode;
            miss_addr  = 32'hFFFF_FFC8;
         end
         @(negedge clk);
         beat_valid = 1'b0;
         miss_valid = 1'b0;
         if (cpu_valid === 1'b1) fwd_cnt++;
         check(cpu_valid === (e == w), "R6 forward timing", 64'(cpu_valid), 64'(e == w));
         if (e == w)
            check(cpu_data === word_val(seed, w), "R6 forward data", cpu_data,
                  word_val(seed, w));
         if (k == 3)
            check(busy === 1'b1, "R2 miss ignored while busy", 64'(busy), 64'd1);
         if (k < NW - 1)
            check(line_done === 1'b0, "R9 no early done", 64'(line_done), 64'd0);
      end
      check(line_done === 1'b1, "R9 done after last beat", 64'(line_done), 64'd1);
      check(busy === 1'b0, "R9 idle at done", 64'(busy), 64'd0);
      check(fwd_cnt == 1, "R7 single forward", 64'(fwd_cnt), 64'd1);
      for (int i = 0; i < NW; i++)
         check(line_data[i*64 +: 64] === word_val(seed, i), "R5 word placement",
               line_data[i*64 +: 64], word_val(seed, i));
      if (chain) begin
         miss_valid = 1'b1;
         miss_mode  = 1'b1;
         miss_addr  = line_base(seed + 8'd1) + 32'd16;
         @(negedge clk);
         miss_valid = 1'b0;
         check(busy === 1'b1 && mem_req_valid === 1'b1, "R10 accept at done",
               64'({busy, mem_req_valid}), 64'h3);
         check(mem_req_addr === line_base(seed + 8'd1) + 32'd16, "R10 next request",
               64'(mem_req_addr), 64'(line_base(seed + 8'd1) + 32'd16));
      end else begin
         @(negedge clk);
         check(line_done === 1'b0 && busy === 1'b0, "R9 done pulse ends",
               64'({line_done, busy}), 64'd0);
      end
   endtask

   task automatic check_reset_state(input string tag);
      check(busy === 1'b0 && mem_req_valid === 1'b0 && cpu_valid === 1'b0 &&
            line_done === 1'b0, tag,
            64'({busy, mem_req_valid, cpu_valid, line_done}), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state("R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state("R1 after reset");

      foreach (VEC[v])
         run_miss(VEC[v][19], int'(VEC[v][18:16]), VEC[v][15:8], VEC[v][7:0], 1'b0);

      // back-to-back miss in the completion cycle, then reset mid-request
      run_miss(1'b1, 6, 8'h24, 8'h9C, 1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_reset_state("R1 reset mid-refill");
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state("R1 idle after re-reset");
      run_miss(1'b0, 1, 8'h03, 8'hC3, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule